// File: doc/BRIEF.md
# Banked Peripheral Clock Gate Register File

This block keeps one clock-enable bit for every peripheral on the chip, up to 64 of them. The bits are split into banks of 32. Software turns clocks on by writing ones to a bank's set register, turns them off by writing ones to its clear register, and reads the live gate state from its state register. The `gate_en` outputs feed the clock-enable inputs of the gating cells elsewhere in the chip. Peripheral N sits in bank N/32 at bit N%32.

The two lowest peripheral numbers carry the always-running clocks. Their bits are tied on, and set or clear writes to them change nothing.

Accesses use a single-cycle strobe: `bus_sel` with `bus_we` high is a write, which takes effect at that clock edge. `bus_sel` with `bus_we` low is a read. A read is answered one cycle later on `bus_rdata`, with `bus_rvalid` high for that cycle.

A two-state bus machine runs the responses:
- IDLE goes to RESP on a read request ("read accept").
- RESP stays in RESP on a back-to-back read ("read chain").
- RESP returns to IDLE on any other cycle ("response done").
- IDLE stays in IDLE on a write or on an idle cycle ("hold").

Top module: `clkgate_regs`

## Requirements
- R1: After reset, every gateable bit of `gate_en` is 0, `gate_en[1:0]` is 2'b11, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: A write to a bank's set register (offset 0x0 within the bank) turns on each gate whose data bit is 1. Bits written 0 keep their value.
- R3: A write to a bank's clear register (offset 0x4 within the bank) turns off each gate whose data bit is 1. Bits written 0 keep their value.
- R4: A read of a bank's state register (offset 0x8 within the bank) returns, in the following cycle, the gate bits of that bank as they were at the read edge. `bus_rvalid` is high in that cycle.
- R5: Bank b occupies byte addresses 0x10*b to 0x10*b+0xF. Peripheral N is controlled by bit N%32 of bank N/32. Bank 0 is at 0x00/0x04/0x08 and bank 1 is at 0x10/0x14/0x18.
- R6: `gate_en[0]` and `gate_en[1]` stay 1 at all times after reset, whatever is written.
- R7: Writes to a state register, to offset 0xC of a bank, or to a bank beyond the last one leave every gate unchanged. Reads of set, clear, offset 0xC or unmapped addresses return 0.
- R8: Set and clear writes to the same bit in consecutive cycles are applied in order, so the later write decides the bit.
- R9: `bus_rvalid` is high only in the cycle after a read request. Writes and idle cycles produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| gate_en | output | 64 | Clock enable per peripheral number |

## Verification
The bench builds the block with its defaults: 64 peripherals in two full 32-bit banks, an 8-bit address, and two locked low numbers. With these values the top peripheral (63), the lowest bit of the second bank (32) and the locked bits are all reachable. The 8-bit address also reaches a third, unmapped bank at 0x20, which the bench uses for the decode checks. Because the banks are full, there are no bits tied off above the last peripheral; a peripheral count that is not a multiple of 32 would be needed to reach that path.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Register kind within a bank, taken from byte-address bits [3:2]
    typedef enum logic [1:0] {
        REG_SET  = 2'd0,
        REG_CLR  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;

    // Bus response state machine
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } bus_state_e;

    // Each bank spans 16 bytes
    localparam int BANK_SPAN_LOG2 = 4;

endpackage

// File: rtl/clkgate_decode.sv
module clkgate_decode
    import clkgate_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output reg_kind_e            kind
);
    localparam int BF_W = ADDR_W - BANK_SPAN_LOG2;

    logic [BF_W-1:0] bank_field;
    logic            word_ok;

    always_comb begin
        bank_field = addr[ADDR_W-1:BANK_SPAN_LOG2];
        word_ok    = (addr[1:0] == 2'b00);
        kind       = word_ok ? reg_kind_e'(addr[3:2]) : REG_NONE;
    end

    // One compare per bank; an out-of-range bank field matches none
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign bank_hit[b] = word_ok && (bank_field == BF_W'(b));
    end

endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank #(
    parameter int BANK_W   = 32,
    parameter int BASE_ID  = 0,
    parameter int NUM_IDS  = 64,
    parameter int LOCK_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] gate
);
    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
        localparam int ID = BASE_ID + i;
        if (ID < LOCK_CNT) begin : g_locked
            // Always-running clock
            assign gate[i] = 1'b1;
        end else if (ID >= NUM_IDS) begin : g_absent
            // No peripheral behind this bit
            assign gate[i] = 1'b0;
        end else begin : g_flop
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else if (set_we && wdata[i]) begin
                    q <= 1'b1;
                end else if (clr_we && wdata[i]) begin
                    q <= 1'b0;
                end
            end
            assign gate[i] = q;
        end
    end

endmodule

// File: rtl/clkgate_bus_fsm.sv
module clkgate_bus_fsm
    import clkgate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_fire,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    bus_state_e state, state_nx;
    logic       rd_req;

    assign rd_req  = sel && !we;
    assign wr_fire = sel && we;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: state_nx = rd_req ? S_RESP : S_IDLE;   // read accept / hold
            S_RESP: state_nx = rd_req ? S_RESP : S_IDLE;   // read chain / response done
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs: read data is captured on the read edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= rd_word;
        end
    end

    assign rvalid = (state == S_RESP);

endmodule

// File: rtl/clkgate_regs.sv
module clkgate_regs
    import clkgate_pkg::*;
#(
    parameter int NUM_IDS  = 64,
    parameter int BANK_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int LOCK_CNT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BANK_W-1:0]  bus_wdata,
    output logic [BANK_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    output logic [NUM_IDS-1:0] gate_en
);
    localparam int NUM_BANKS = (NUM_IDS + BANK_W - 1) / BANK_W;

    logic [NUM_BANKS-1:0] bank_hit;
    reg_kind_e            kind;
    logic                 wr_fire;
    logic [BANK_W-1:0]    bank_gate [NUM_BANKS];
    logic [BANK_W-1:0]    rd_word;

    clkgate_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS)
    ) u_decode (
        .addr    (bus_addr),
        .bank_hit(bank_hit),
        .kind    (kind)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic set_we, clr_we;
        assign set_we = wr_fire && bank_hit[b] && (kind == REG_SET);
        assign clr_we = wr_fire && bank_hit[b] && (kind == REG_CLR);

        clkgate_bank #(
            .BANK_W  (BANK_W),
            .BASE_ID (b * BANK_W),
            .NUM_IDS (NUM_IDS),
            .LOCK_CNT(LOCK_CNT)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .set_we(set_we),
            .clr_we(clr_we),
            .wdata (bus_wdata),
            .gate  (bank_gate[b])
        );
    end

    // Flatten bank bits onto the per-peripheral outputs
    for (genvar n = 0; n < NUM_IDS; n++) begin : g_out
        assign gate_en[n] = bank_gate[n / BANK_W][n % BANK_W];
    end

    // Read mux: only state registers return data
    always_comb begin
        rd_word = '0;
        if (kind == REG_STAT) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_hit[b]) begin
                    rd_word = bank_gate[b];
                end
            end
        end
    end

    clkgate_bus_fsm #(
        .DATA_W(BANK_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .we     (bus_we),
        .rd_word(rd_word),
        .wr_fire(wr_fire),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

endmodule

// File: rtl/clkgate_regs_chk.sv
module clkgate_regs_chk #(
    parameter int NUM_IDS  = 64,
    parameter int BANK_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int LOCK_CNT = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [BANK_W-1:0]  bus_wdata,
    input logic [BANK_W-1:0]  bus_rdata,
    input logic               bus_rvalid,
    input logic [NUM_IDS-1:0] gate_en
);
    localparam logic [BANK_W-1:0] LOCK_MASK = BANK_W'((64'd1 << LOCK_CNT) - 64'd1);

    logic wr, rd;
    assign wr = bus_sel && bus_we;
    assign rd = bus_sel && !bus_we;

    // R6: locked clocks never drop
    p_locked_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en[BANK_W-1:0] & LOCK_MASK) == LOCK_MASK);

    // R2: set register write turns the written ones on
    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(0)) |=>
        ((gate_en[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: clear register write turns the written ones off
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(4)) |=>
        ((gate_en[BANK_W-1:0] & $past(bus_wdata) & ~LOCK_MASK) == '0));

    // R4: state read returns the gate bits seen at the read edge
    p_stat_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == ADDR_W'(8)) |=>
        (bus_rvalid && bus_rdata == $past(gate_en[BANK_W-1:0])));

    // R7: no write, no gate change
    p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(gate_en));

    // R9: a response only follows a read
    p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !bus_rvalid);

endmodule

bind clkgate_regs clkgate_regs_chk #(
    .NUM_IDS (NUM_IDS),
    .BANK_W  (BANK_W),
    .ADDR_W  (ADDR_W),
    .LOCK_CNT(LOCK_CNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .gate_en   (gate_en)
);

// File: tb/clkgate_regs_tb.sv
module clkgate_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [63:0] gate_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    clkgate_regs dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .gate_en   (gate_en)
    );

    // {is_read, addr, wdata, expected gate hi, expected gate lo, expected rdata}
    localparam int NV = 17;
    localparam logic [136:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h0000_00F0, 32'h0000_0000, 32'h0000_00F3, 32'h0},           // R2
        {1'b1, 8'h08, 32'h0,         32'h0000_0000, 32'h0000_00F3, 32'h0000_00F3},   // R4
        {1'b0, 8'h04, 32'h0000_0033, 32'h0000_0000, 32'h0000_00C3, 32'h0},           // R3 R6
        {1'b0, 8'h10, 32'h8000_0001, 32'h8000_0001, 32'h0000_00C3, 32'h0},           // R5
        {1'b1, 8'h18, 32'h0,         32'h8000_0001, 32'h0000_00C3, 32'h8000_0001},   // R5
        {1'b0, 8'h14, 32'h0000_0001, 32'h8000_0000, 32'h0000_00C3, 32'h0},           // R5
        {1'b0, 8'h08, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_00C3, 32'h0},           // R7
        {1'b0, 8'h20, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_00C3, 32'h0},           // R7
        {1'b0, 8'h0C, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_00C3, 32'h0},           // R7
        {1'b1, 8'h00, 32'h0,         32'h8000_0000, 32'h0000_00C3, 32'h0},           // R7
        {1'b1, 8'h04, 32'h0,         32'h8000_0000, 32'h0000_00C3, 32'h0},           // R7
        {1'b0, 8'h04, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0003, 32'h0},           // R6
        {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0},           // R2
        {1'b1, 8'h08, 32'h0,         32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},   // R4
        {1'b0, 8'h14, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0},           // R3
        {1'b1, 8'h18, 32'h0,         32'h0000_0000, 32'hFFFF_FFFF, 32'h0},           // R4
        {1'b1, 8'h28, 32'h0,         32'h0000_0000, 32'hFFFF_FFFF, 32'h0}            // R7
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: driven at a falling edge, results sampled at the next falling edge
    task automatic access(input bit is_rd, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_we    = !is_rd;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(gate_en == 64'h3, "R1 gate after reset", gate_en, 64'h3);
        check(bus_rvalid == 1'b0 && bus_rdata == '0, "R1 bus after reset",
              {31'b0, bus_rvalid, bus_rdata}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [136:0] v;
            v = VEC[i];
            access(v[136], v[135:128], v[127:96]);
            check(gate_en == v[95:32], $sformatf("R2/R3/R5/R6/R7 vec %0d gate", i),
                  gate_en, v[95:32]);
            check(bus_rvalid == v[136], $sformatf("R9 vec %0d rvalid", i),
                  {63'b0, bus_rvalid}, {63'b0, v[136]});
            if (v[136]) begin
                check(bus_rdata == v[31:0], $sformatf("R4 vec %0d rdata", i),
                      {32'b0, bus_rdata}, {32'b0, v[31:0]});
            end
        end

        // R8: set then clear bit 40 on consecutive cycles, clear wins
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_0100;
        @(negedge clk);
        bus_addr = 8'h14;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        check(gate_en[40] == 1'b0, "R8 set then clear", {63'b0, gate_en[40]}, 64'h0);

        // R8: clear then set bit 9 back to back, set wins
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_0200;
        @(negedge clk);
        bus_addr = 8'h00;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        check(gate_en[9] == 1'b1, "R8 clear then set", {63'b0, gate_en[9]}, 64'h1);

        // R9: back-to-back reads keep rvalid high, then it drops
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h08;
        @(negedge clk);
        bus_addr = 8'h18;
        check(bus_rvalid == 1'b1 && bus_rdata == 32'hFFFF_FFFF, "R9 first chained read",
              {31'b0, bus_rvalid, bus_rdata}, {31'b0, 1'b1, 32'hFFFF_FFFF});
        @(negedge clk);
        bus_sel = 1'b0;
        check(bus_rvalid == 1'b1 && bus_rdata == 32'h0, "R9 second chained read",
              {31'b0, bus_rvalid, bus_rdata}, {31'b0, 1'b1, 32'h0});
        @(negedge clk);
        check(bus_rvalid == 1'b0, "R9 rvalid drops", {63'b0, bus_rvalid}, 64'h0);

        // R1: reset in mid-run restores the reset values
        rst_n = 1'b0;
        @(negedge clk);
        check(gate_en == 64'h3, "R1 gate after second reset", gate_en, 64'h3);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule